// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog. Software must service it at regular intervals, or it raises an interrupt, a reset request, or both. A strap input decides whether counting begins straight after reset. If the strap is low, the watchdog waits until software starts it through a configuration write. Servicing is a two-write key sequence sent to a dedicated register. In windowed mode, completing that sequence too early also counts as a fault.

The count advances on enable ticks, not on the block clock. One tick comes from the system clock domain and one from the internal RC oscillator, and an input picks which one is used. When the configuration asks for it, an asserted debug-halt input freezes the count. The reset generator and the oscillators sit outside the block.

The control flow is a state machine with four states:
- `ST_OFF`: idle, configuration open.
- `ST_RUN`: counting, no key seen.
- `ST_KEY`: first key seen, waiting for the second.
- `ST_BITE`: reset requested. This state is terminal until `rst_n`.

The transitions are:
- OFF→RUN on a software start.
- RUN→KEY on the first key.
- KEY→RUN on a valid completion, or on any fault answered by an interrupt.
- RUN/KEY→BITE on a fault whose answer is reset.

Top module: `wdog_window_top`

## Requirements
- R1: With `boot_en` low during reset, the block sits in `ST_OFF` with `irq` and `rst_req` low and never faults. With `boot_en` high, it counts from `DEF_TIMEOUT` at once with the reset response.
- R2: A write to address 0 while off starts the watchdog when bit0 is 1, and the counter loads the timeout. The other fields of this write are:
  - bit1: windowed mode.
  - bits 3:2: response, where 00 is reset, 01 is interrupt, 10 is interrupt then reset, and 11 is reset.
  - bit4: freeze on debug halt.

  Once the watchdog runs, writes to address 0 and to the window register (address 2) are ignored.
- R3: The timeout register (address 1) takes only the first write after reset. Later writes are ignored.
- R4: The count drops by one per selected tick: `sys_tick` when `src_sel`=0, `rc_tick` when `src_sel`=1. A tick that arrives at count 0 is a timeout, so a timeout comes timeout+1 ticks after a load.
- R5: Writing 0xA602 and then 0xB480 to address 3 is a valid service. It reloads the counter and clears `irq`. Any other value written to address 3 is a fault.
- R6: In windowed mode, a completed service while the count is above the window value is a fault.
- R7: With the reset response, a fault raises `rst_req`, which then stays high until `rst_n`.
- R8: With the interrupt response, a fault raises `irq` and reloads the counter. `irq` then stays high until a valid service.
- R9: With interrupt-then-reset, the first fault raises `irq` and reloads the counter. A fault while `irq` is still pending raises `rst_req`.
- R10: With freeze enabled, the count holds while `dbg_halt` is high. With freeze disabled, `dbg_halt` has no effect.
- R11: A valid service completed in the same cycle as a timeout wins: the counter reloads and no fault is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Strap: start counting out of reset |
| sys_tick | input | 1 | Count enable from the system clock domain |
| rc_tick | input | 1 | Count enable from the RC oscillator |
| src_sel | input | 1 | Tick source select (1 = RC) |
| dbg_halt | input | 1 | Debug halt indication |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | Watchdog reset request |

## Verification
Two of this block's events can land on the same clock edge: the counter expiring, and the second service key arriving. The bench sets this up by writing the first key in the cycle that brings the count to zero. The second key then meets the expiring tick. The case is judged correct if `irq` stays low and the next interrupt comes a full timeout+1 ticks later, which shows the reload took priority over the fault.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_KEY  = 2'd2,
        ST_BITE = 2'd3
    } wdt_state_e;

    typedef enum logic [1:0] {
        RSP_RESET     = 2'b00,
        RSP_IRQ       = 2'b01,
        RSP_IRQ_RST   = 2'b10,
        RSP_RESET_ALT = 2'b11
    } wdt_resp_e;

    localparam logic [15:0] KEY_FIRST  = 16'hA602;
    localparam logic [15:0] KEY_SECOND = 16'hB480;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_TMO = 2'd1;
    localparam logic [1:0] ADDR_WIN = 2'd2;
    localparam logic [1:0] ADDR_SVC = 2'd3;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int DEF_TIMEOUT = 1000,
    parameter int DEF_WINDOW  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cfg_open,
    output logic [CNT_W-1:0]  tmo_val,
    output logic [CNT_W-1:0]  win_val,
    output logic              win_mode,
    output wdt_resp_e         resp,
    output logic              freeze_en,
    output logic              sw_start,
    output logic              svc_we
);

    logic tmo_locked;
    logic cfg_hit;
    logic tmo_hit;
    logic win_hit;

    always_comb begin
        cfg_hit  = reg_we && (reg_addr == ADDR_CFG) && cfg_open;
        tmo_hit  = reg_we && (reg_addr == ADDR_TMO) && !tmo_locked;
        win_hit  = reg_we && (reg_addr == ADDR_WIN) && cfg_open;
        svc_we   = reg_we && (reg_addr == ADDR_SVC);
        sw_start = cfg_hit && reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_val    <= CNT_W'(DEF_TIMEOUT);
            tmo_locked <= 1'b0;
        end else if (tmo_hit) begin
            tmo_val    <= reg_wdata[CNT_W-1:0];
            tmo_locked <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_mode  <= 1'b0;
            resp      <= RSP_RESET;
            freeze_en <= 1'b0;
        end else if (cfg_hit) begin
            win_mode  <= reg_wdata[1];
            resp      <= wdt_resp_e'(reg_wdata[3:2]);
            freeze_en <= reg_wdata[4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_val <= CNT_W'(DEF_WINDOW);
        end else if (win_hit) begin
            win_val <= reg_wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W       = 16,
    parameter int DEF_TIMEOUT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             sys_tick,
    input  logic             rc_tick,
    input  logic             src_sel,
    input  logic             dbg_halt,
    input  logic             freeze_en,
    input  logic [CNT_W-1:0] tmo_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic tick_sel;
    logic frozen;
    logic step;

    always_comb begin
        tick_sel = src_sel ? rc_tick : sys_tick;
        frozen   = freeze_en && dbg_halt;
        step     = run && tick_sel && !frozen;
        expire   = step && (count == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_W'(DEF_TIMEOUT);
        end else if (load) begin
            count <= tmo_val;
        end else if (step && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en,
    input  logic              sw_start,
    input  logic              svc_we,
    input  logic [DATA_W-1:0] svc_data,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  win_val,
    input  logic              win_mode,
    input  wdt_resp_e         resp,
    output logic              load,
    output logic              run,
    output logic              cfg_open,
    output logic              irq_pend,
    output logic              rst_req
);

    wdt_state_e state;
    wdt_state_e nxt;
    logic       fault;
    logic       good;
    logic       irq_set;

    // next state and event decode
    always_comb begin
        nxt     = state;
        load    = 1'b0;
        fault   = 1'b0;
        good    = 1'b0;
        irq_set = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (sw_start) begin
                    nxt  = ST_RUN;
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (svc_we) begin
                    if (svc_data == DATA_W'(KEY_FIRST)) nxt = ST_KEY;
                    else                                fault = 1'b1;
                end
                if (expire) fault = 1'b1;
            end
            ST_KEY: begin
                if (svc_we) begin
                    if (svc_data == DATA_W'(KEY_SECOND)) begin
                        if (win_mode && (count > win_val)) fault = 1'b1;
                        else                               good  = 1'b1;
                    end else begin
                        fault = 1'b1;
                    end
                end
                if (expire && !good) fault = 1'b1;
            end
            ST_BITE: begin
                nxt = ST_BITE;
            end
        endcase
        if (good) begin
            nxt  = ST_RUN;
            load = 1'b1;
        end else if (fault) begin
            if ((resp == RSP_IRQ) || ((resp == RSP_IRQ_RST) && !irq_pend)) begin
                nxt     = ST_RUN;
                load    = 1'b1;
                irq_set = 1'b1;
            end else begin
                nxt = ST_BITE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= boot_en ? ST_RUN : ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // pending interrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
        end else if (good) begin
            irq_pend <= 1'b0;
        end else if (irq_set) begin
            irq_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        run      = (state == ST_RUN) || (state == ST_KEY);
        cfg_open = (state == ST_OFF);
        rst_req  = (state == ST_BITE);
    end

endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top
    import wdt_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int DEF_TIMEOUT = 1000,
    parameter int DEF_WINDOW  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_en,
    input  logic              sys_tick,
    input  logic              rc_tick,
    input  logic              src_sel,
    input  logic              dbg_halt,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              irq,
    output logic              rst_req
);

    logic [CNT_W-1:0] tmo_val;
    logic [CNT_W-1:0] win_val;
    logic [CNT_W-1:0] count;
    logic             win_mode;
    wdt_resp_e        resp;
    logic             freeze_en;
    logic             sw_start;
    logic             svc_we;
    logic             load;
    logic             run;
    logic             cfg_open;
    logic             expire;
    logic             irq_pend;

    wdt_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W),
        .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_WINDOW(DEF_WINDOW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg_open(cfg_open), .tmo_val(tmo_val),
        .win_val(win_val), .win_mode(win_mode), .resp(resp),
        .freeze_en(freeze_en), .sw_start(sw_start), .svc_we(svc_we)
    );

    wdt_counter #(
        .CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .run(run),
        .sys_tick(sys_tick), .rc_tick(rc_tick), .src_sel(src_sel),
        .dbg_halt(dbg_halt), .freeze_en(freeze_en), .tmo_val(tmo_val),
        .count(count), .expire(expire)
    );

    wdt_fsm #(
        .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .sw_start(sw_start),
        .svc_we(svc_we), .svc_data(reg_wdata), .expire(expire),
        .count(count), .win_val(win_val), .win_mode(win_mode), .resp(resp),
        .load(load), .run(run), .cfg_open(cfg_open), .irq_pend(irq_pend),
        .rst_req(rst_req)
    );

    assign irq = irq_pend;

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              rst_req,
    input logic              cfg_open,
    input logic              run,
    input logic              load,
    input logic              freeze_en,
    input logic              dbg_halt,
    input logic              sys_tick,
    input logic              rc_tick,
    input logic              src_sel,
    input logic [CNT_W-1:0]  count
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open |-> (!irq && !rst_req)); // R1

    AST_BITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req); // R7

    AST_IRQ_CLEAR_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we && (reg_addr == ADDR_SVC) && (reg_wdata == DATA_W'(KEY_SECOND)))); // R5

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && freeze_en && dbg_halt && !load) |=> (count == $past(count))); // R10

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(src_sel ? rc_tick : sys_tick) && !load) |=> (count == $past(count))); // R4

endmodule

bind wdog_window_top wdog_window_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .rst_req(rst_req), .cfg_open(cfg_open),
    .run(run), .load(load), .freeze_en(freeze_en), .dbg_halt(dbg_halt),
    .sys_tick(sys_tick), .rc_tick(rc_tick), .src_sel(src_sel), .count(count)
);

// File: tb/tb_wdog_window_top.sv
module tb_wdog_window_top;

    localparam int DW = 16;
    localparam logic [15:0] K1 = 16'hA602;
    localparam logic [15:0] K2 = 16'hB480;
    localparam logic [15:0] C_RST    = 16'h0001;
    localparam logic [15:0] C_IRQ    = 16'h0005;
    localparam logic [15:0] C_IRQRST = 16'h0009;
    localparam logic [15:0] C_WINRST = 16'h0003;
    localparam logic [15:0] C_FRZIRQ = 16'h0015;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_en = 1'b0;
    logic          sys_tick = 1'b1;
    logic          rc_tick = 1'b0;
    logic          src_sel = 1'b0;
    logic          dbg_halt = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic          irq;
    logic          rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_window_top #(.DATA_W(DW), .CNT_W(16), .DEF_TIMEOUT(20), .DEF_WINDOW(0)) dut (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .sys_tick(sys_tick),
        .rc_tick(rc_tick), .src_sel(src_sel), .dbg_halt(dbg_halt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic boot);
        rst_n   = 1'b0;
        boot_en = boot;
        step(2);
        rst_n   = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step(1);
        reg_we    = 1'b0;
    endtask

    task automatic t_off();
        do_reset(1'b0);
        chk("R1 reset irq", irq, 1'b0);
        chk("R1 reset rst_req", rst_req, 1'b0);
        step(60);
        chk("R1 idle no fault", rst_req | irq, 1'b0);
    endtask

    task automatic t_boot();
        do_reset(1'b1);
        step(20);
        chk("R1 boot before timeout", rst_req, 1'b0);
        step(1);
        chk("R1 R7 boot timeout resets", rst_req, 1'b1);
        step(5);
        chk("R7 reset held", rst_req, 1'b1);
    endtask

    task automatic t_write_once();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd1, 16'd30);
        wr(2'd0, C_IRQ);
        step(5);
        chk("R3 no early irq", irq, 1'b0);
        step(1);
        chk("R3 R8 first timeout value used", irq, 1'b1);
        chk("R8 no reset on irq response", rst_req, 1'b0);
    endtask

    task automatic t_service();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_IRQ);
        step(3);
        wr(2'd3, K1);
        wr(2'd3, K2);
        step(5);
        chk("R5 service reloaded", irq, 1'b0);
        step(1);
        chk("R4 R5 timeout after reload", irq, 1'b1);
        wr(2'd3, K1);
        wr(2'd3, K2);
        chk("R5 R8 service clears irq", irq, 1'b0);
    endtask

    task automatic t_badkey();
        do_reset(1'b0);
        wr(2'd1, 16'd50);
        wr(2'd0, C_RST);
        wr(2'd3, 16'h1234);
        chk("R5 R7 wrong key faults", rst_req, 1'b1);
    endtask

    task automatic t_irq_rst();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_IRQRST);
        step(6);
        chk("R9 first strike irq", irq, 1'b1);
        chk("R9 first strike no reset", rst_req, 1'b0);
        step(5);
        chk("R9 second strike pending", rst_req, 1'b0);
        step(1);
        chk("R9 second strike resets", rst_req, 1'b1);
    endtask

    task automatic t_irq_rst_cleared();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_IRQRST);
        step(6);
        wr(2'd3, K1);
        wr(2'd3, K2);
        chk("R9 service clears irq", irq, 1'b0);
        step(6);
        chk("R9 strike after service is irq", irq, 1'b1);
        chk("R9 strike after service no reset", rst_req, 1'b0);
    endtask

    task automatic t_window();
        do_reset(1'b0);
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd3);
        wr(2'd0, C_WINRST);
        wr(2'd3, K1);
        wr(2'd3, K2);
        chk("R6 early service faults", rst_req, 1'b1);
        do_reset(1'b0);
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd3);
        wr(2'd0, C_WINRST);
        step(6);
        wr(2'd3, K1);
        wr(2'd3, K2);
        chk("R6 service inside window ok", rst_req, 1'b0);
        step(10);
        chk("R6 reload after window service", rst_req, 1'b0);
        step(1);
        chk("R6 R4 timeout after window reload", rst_req, 1'b1);
    endtask

    task automatic t_freeze();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_FRZIRQ);
        dbg_halt = 1'b1;
        step(30);
        chk("R10 frozen while halted", irq, 1'b0);
        dbg_halt = 1'b0;
        step(5);
        chk("R10 resumes count", irq, 1'b0);
        step(1);
        chk("R10 timeout after resume", irq, 1'b1);
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_IRQ);
        dbg_halt = 1'b1;
        step(6);
        chk("R10 halt ignored without freeze", irq, 1'b1);
        dbg_halt = 1'b0;
    endtask

    task automatic t_source();
        do_reset(1'b0);
        src_sel = 1'b1;
        wr(2'd1, 16'd5);
        wr(2'd0, C_IRQ);
        step(30);
        chk("R4 system tick ignored on rc source", irq, 1'b0);
        for (int i = 0; i < 5; i++) begin
            rc_tick = 1'b1;
            step(1);
            rc_tick = 1'b0;
            step(3);
        end
        chk("R4 five rc ticks no timeout", irq, 1'b0);
        rc_tick = 1'b1;
        step(1);
        rc_tick = 1'b0;
        chk("R4 sixth rc tick times out", irq, 1'b1);
        src_sel = 1'b0;
    endtask

    task automatic t_collide();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_IRQ);
        step(4);
        wr(2'd3, K1);
        wr(2'd3, K2);
        chk("R11 service beats expiry", irq, 1'b0);
        step(5);
        chk("R11 full reload", irq, 1'b0);
        step(1);
        chk("R11 later timeout", irq, 1'b1);
    endtask

    task automatic t_lock();
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        wr(2'd0, C_RST);
        wr(2'd0, C_IRQ);
        step(5);
        chk("R2 config locked irq", irq, 1'b0);
        chk("R2 config locked reset response", rst_req, 1'b1);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1);
        t_off();
        t_boot();
        t_write_once();
        t_service();
        t_badkey();
        t_irq_rst();
        t_irq_rst_cleared();
        t_window();
        t_freeze();
        t_source();
        t_collide();
        t_lock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule